// File: doc/BRIEF.md
# Comparator edge interrupt controller

This block is the digital side of an analog comparator. It brings the raw comparator output into the clock domain through a flop synchronizer and watches the synchronized level for transitions. A rising transition sets one sticky flag and a falling transition sets another. Each flag has its own mask, and one registered interrupt request is raised while any unmasked flag is set.

A small register port holds the control word. The control word drives the comparator enable, the two hysteresis selections and the response-time selection straight to the analog side. The port also exposes the flags and the live synchronized output, and holds a reload value for a settle timer. Turning the comparator on, or changing its hysteresis or response selection, can make the analog output glitch. The settle timer therefore stops new flags from being set until it has counted down to zero.

Top module: `cmp_edge_irq`

## Requirements
- R1: A high-to-low change of the synchronized comparator level sets the falling flag (status register, address 1, bit 1).
- R2: A low-to-high change of the synchronized comparator level sets the rising flag (status register, bit 0).
- R3: A set flag stays set until a status write carries 0 in that flag's bit. Writing 1 to a flag bit leaves it unchanged, and hardware never clears a flag.
- R4: `irq` is a register that equals (rising flag AND control bit 1) OR (falling flag AND control bit 2), taken from the previous cycle.
- R5: Status bit 2 reads the comparator level after a two-flop synchronizer.
- R6: Control register (address 0) bit 0 drives `cmp_en`. A 1 turns the comparator on.
- R7: Control bits [4:3] drive `hyst_pos` and bits [6:5] drive `hyst_neg`, both unchanged. The codes are 0 = off, 1 = 5 mV, 2 = 10 mV and 3 = 20 mV.
- R8: No flag is set while the settle counter is nonzero.
- R9: The settle counter is loaded from the settle register (address 2, reset value 16) on a control write that turns the enable from 0 to 1 or changes bits [8:3]. After that it counts down to 0. Bits [8:7] drive `resp_mode`.
- R10: While the enable is 0, the synchronized level reads 0 and no flag is set. Flags that are already set are kept.
- R11: When an edge would set a flag in the same cycle that a status write clears it, the flag ends up set.
- R12: `bus_rdata` and `bus_rvalid` are registered one cycle after `bus_rd`. Unused bits read 0, and every register resets to 0 except the settle register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_raw | input | 1 | Asynchronous comparator output |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address (0 control, 1 status, 2 settle) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| cmp_en | output | 1 | Comparator enable to analog side |
| hyst_pos | output | 2 | Positive hysteresis code |
| hyst_neg | output | 2 | Negative hysteresis code |
| resp_mode | output | 2 | Response-time selection |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that a read and a write are never issued in the same cycle and that only addresses 0 to 2 are used. They also assume that `cmp_raw` is a level that holds steady for several cycles and does not toggle on every edge. The stimulus changes `cmp_raw` only on falling clock edges and holds each level for at least three cycles, except inside settle windows, where it toggles on purpose. One sequence lines up a falling edge with a clearing write to the same cycle, so that the case where the set and the clear collide is exercised directly.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_SETL = 2'd2
  } reg_addr_e;

  // control word, LSB first: en, rise mask, fall mask, hyst pos, hyst neg, resp
  typedef struct packed {
    logic [1:0] resp;
    logic [1:0] hneg;
    logic [1:0] hpos;
    logic       fmask;
    logic       rmask;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cmpirq_sync.sv
module cmpirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic raw,
  output logic level,
  output logic rise_ev,
  output logic fall_ev
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst || !en) chain[0] <= 1'b0;
          else            chain[0] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst || !en) chain[g] <= 1'b0;
          else            chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !en) prev_q <= 1'b0;
    else            prev_q <= chain[STAGES-1];
  end

  assign level   = chain[STAGES-1];
  assign rise_ev = level & ~prev_q;
  assign fall_ev = ~level & prev_q;

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!level && !rise_ev && !fall_ev)); // R10
endmodule

// File: rtl/cmpirq_regs.sv
module cmpirq_regs
  import cmpirq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SETTLE_W   = 8,
  parameter int SETTLE_RST = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output ctrl_t               ctrl,
  output logic [SETTLE_W-1:0] settle_cfg,
  output logic                reload,
  output logic                clr_rise,
  output logic                clr_fall
);
  ctrl_t               ctrl_q;
  ctrl_t               ctrl_new;
  logic [SETTLE_W-1:0] cfg_q;
  logic                ctrl_wr;
  logic                unused_wdata;

  assign ctrl_new = ctrl_t'(wdata[CTRL_W-1:0]);
  assign ctrl_wr  = wr && (addr == A_CTRL);
  assign unused_wdata = ^wdata;

  // reload on enable turning on or on any analog-mode field change
  assign reload = ctrl_wr && ((!ctrl_q.en && ctrl_new.en) ||
                              (ctrl_new.hpos != ctrl_q.hpos) ||
                              (ctrl_new.hneg != ctrl_q.hneg) ||
                              (ctrl_new.resp != ctrl_q.resp));

  assign clr_rise = wr && (addr == A_STAT) && !wdata[0];
  assign clr_fall = wr && (addr == A_STAT) && !wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cfg_q  <= SETTLE_W'(SETTLE_RST);
    end else if (wr) begin
      if (addr == A_CTRL) ctrl_q <= ctrl_new;
      if (addr == A_SETL) cfg_q  <= wdata[SETTLE_W-1:0];
    end
  end

  assign ctrl       = ctrl_q;
  assign settle_cfg = cfg_q;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> $stable(ctrl_q)); // R6
endmodule

// File: rtl/cmpirq_settle.sv
module cmpirq_settle #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                reload,
  input  logic [SETTLE_W-1:0] cfg,
  output logic                set_ok
);
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (reload)        cnt_q <= cfg;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign set_ok = en && (cnt_q == '0);

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    reload |=> (cnt_q == $past(cfg))); // R9
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!reload && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9
endmodule

// File: rtl/cmpirq_flags.sv
module cmpirq_flags (
  input  logic clk,
  input  logic rst,
  input  logic rise_ev,
  input  logic fall_ev,
  input  logic set_ok,
  input  logic clr_rise,
  input  logic clr_fall,
  input  logic rmask,
  input  logic fmask,
  output logic rise_flag,
  output logic fall_flag,
  output logic irq
);
  logic rise_q, fall_q, irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (rise_ev && set_ok) rise_q <= 1'b1;
      else if (clr_rise)     rise_q <= 1'b0;
      if (fall_ev && set_ok) fall_q <= 1'b1;
      else if (clr_fall)     fall_q <= 1'b0;
      irq_q <= (rise_q & rmask) | (fall_q & fmask);
    end
  end

  assign rise_flag = rise_q;
  assign fall_flag = fall_q;
  assign irq       = irq_q;

  AST_RISE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rise_q && !clr_rise) |=> rise_q); // R3
  AST_FALL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fall_q && !clr_fall) |=> fall_q); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (fall_ev && set_ok && clr_fall) |=> fall_q); // R11
  AST_RISE_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(rise_q) |-> $past(rise_ev && set_ok)); // R8
  AST_FALL_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(fall_q) |-> $past(fall_ev && set_ok)); // R8
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    ((rise_q && rmask) || (fall_q && fmask)) |=> irq_q); // R4
endmodule

// File: rtl/cmp_edge_irq.sv
module cmp_edge_irq
  import cmpirq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SETTLE_W    = 8,
  parameter int SETTLE_RST  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_raw,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              cmp_en,
  output logic [1:0]        hyst_pos,
  output logic [1:0]        hyst_neg,
  output logic [1:0]        resp_mode,
  output logic              irq
);
  ctrl_t               ctrl;
  logic [SETTLE_W-1:0] settle_cfg;
  logic                reload, clr_rise, clr_fall;
  logic                level, rise_ev, fall_ev, set_ok;
  logic                rise_flag, fall_flag;
  logic [DATA_W-1:0]   rd_mux;
  logic [DATA_W-1:0]   rdata_q;
  logic                rvalid_q;

  cmpirq_regs #(
    .DATA_W(DATA_W), .SETTLE_W(SETTLE_W), .SETTLE_RST(SETTLE_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .ctrl(ctrl), .settle_cfg(settle_cfg), .reload(reload),
    .clr_rise(clr_rise), .clr_fall(clr_fall)
  );

  cmpirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .en(ctrl.en), .raw(cmp_raw),
    .level(level), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  cmpirq_settle #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk(clk), .rst(rst), .en(ctrl.en), .reload(reload),
    .cfg(settle_cfg), .set_ok(set_ok)
  );

  cmpirq_flags u_flags (
    .clk(clk), .rst(rst), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .set_ok(set_ok), .clr_rise(clr_rise), .clr_fall(clr_fall),
    .rmask(ctrl.rmask), .fmask(ctrl.fmask),
    .rise_flag(rise_flag), .fall_flag(fall_flag), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL: rd_mux[CTRL_W-1:0]   = ctrl;
      A_STAT: rd_mux[2:0]          = {level, fall_flag, rise_flag};
      A_SETL: rd_mux[SETTLE_W-1:0] = settle_cfg;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      rdata_q  <= bus_rd ? rd_mux : '0;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign cmp_en     = ctrl.en;
  assign hyst_pos   = ctrl.hpos;
  assign hyst_neg   = ctrl.hneg;
  assign resp_mode  = ctrl.resp;

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R12
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid); // R12
endmodule

// File: tb/tb_cmp_edge_irq.sv
module tb_cmp_edge_irq;
  localparam int DW = 16;
  localparam time CYC = 20ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmp_raw = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid, cmp_en, irq;
  logic [1:0]    hyst_pos, hyst_neg, resp_mode;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    string         req;
    logic [DW-1:0] exp;
  } item_t;
  item_t sbq[$];

  always #(CYC/2) clk = ~clk;

  cmp_edge_irq dut (
    .clk(clk), .rst(rst), .cmp_raw(cmp_raw), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cmp_en(cmp_en), .hyst_pos(hyst_pos),
    .hyst_neg(hyst_neg), .resp_mode(resp_mode), .irq(irq)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (sbq.size() == 0) begin
        total++; bad++;
        $display("FAIL R12 actual=unexpected read expected=none");
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(it.req, bus_rdata, it.exp);
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, logic [DW-1:0] exp, string req);
    item_t it;
    @(negedge clk);
    it.req = req; it.exp = exp;
    sbq.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cycles(4);
    rst = 1'b0;
    cycles(1);
    // reset state (R12, R6, R7, R4)
    check("R12 reset irq", {15'd0, irq}, 16'd0);
    check("R6 reset enable", {15'd0, cmp_en}, 16'd0);
    check("R7 reset hyst", {12'd0, hyst_pos, hyst_neg}, 16'd0);
    rd(2'd0, 16'h0000, "R12 ctrl reset");
    rd(2'd1, 16'h0000, "R12 status reset");
    rd(2'd2, 16'd16, "R12 settle reset");

    wr(2'd2, 16'd3);
    rd(2'd2, 16'd3, "R12 settle readback");

    // disabled: level stays 0, no flags (R10)
    cmp_raw = 1'b1;
    cycles(6);
    rd(2'd1, 16'h0000, "R10 disabled status");

    // enable with hyst pos=1 neg=3; spurious rise is inside settle window (R8)
    wr(2'd0, 16'd105);
    check("R6 enable out", {15'd0, cmp_en}, 16'd1);
    check("R7 hyst_pos", {14'd0, hyst_pos}, 16'd1);
    check("R7 hyst_neg", {14'd0, hyst_neg}, 16'd3);
    cycles(10);
    rd(2'd1, 16'h0004, "R8 enable glitch not flagged, R5 live");

    // falling edge (R1)
    cmp_raw = 1'b0;
    cycles(6);
    rd(2'd1, 16'h0002, "R1 falling flag");
    check("R4 masked irq", {15'd0, irq}, 16'd0);

    // rising edge (R2, R5)
    cmp_raw = 1'b1;
    cycles(6);
    rd(2'd1, 16'h0007, "R2 rising flag");

    // write 1 keeps, write 0 clears (R3)
    wr(2'd1, 16'h0003);
    rd(2'd1, 16'h0007, "R3 write one no effect");
    wr(2'd1, 16'h0002);
    rd(2'd1, 16'h0006, "R3 clear rising only");

    // masks (R4)
    wr(2'd0, 16'd109);
    cycles(2);
    check("R4 fall mask irq", {15'd0, irq}, 16'd1);
    wr(2'd0, 16'd107);
    cycles(2);
    check("R4 rise mask only irq", {15'd0, irq}, 16'd0);
    wr(2'd1, 16'h0000);
    rd(2'd1, 16'h0004, "R3 clear all");

    // hysteresis change reloads settle counter (R9, R8)
    wr(2'd2, 16'd20);
    wr(2'd0, 16'd75);
    cmp_raw = 1'b0;
    cycles(4);
    cmp_raw = 1'b1;
    cycles(4);
    rd(2'd1, 16'h0004, "R9 hyst change blocks flags");
    cycles(20);
    cmp_raw = 1'b0;
    cycles(6);
    rd(2'd1, 16'h0002, "R1 fall after settle");
    check("R4 fall unmasked off", {15'd0, irq}, 16'd0);
    cmp_raw = 1'b1;
    cycles(6);
    check("R4 rise unmasked irq", {15'd0, irq}, 16'd1);

    // response selection change reloads too (R9)
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'd203);
    check("R9 resp_mode out", {14'd0, resp_mode}, 16'd1);
    cmp_raw = 1'b0;
    cycles(6);
    rd(2'd1, 16'h0000, "R9 resp change blocks flags");

    // set wins over same-cycle clear (R11)
    cycles(25);
    cmp_raw = 1'b1;
    cycles(6);
    wr(2'd1, 16'h0000);
    @(negedge clk);
    cmp_raw = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h0000;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(2'd1, 16'h0002, "R11 set beats clear");

    // disable keeps flags, blocks new ones (R10, R6)
    wr(2'd0, 16'd0);
    check("R6 disable out", {15'd0, cmp_en}, 16'd0);
    cmp_raw = 1'b1;
    cycles(6);
    rd(2'd1, 16'h0002, "R10 disabled no new flag");

    cycles(4);
    if (sbq.size() != 0) begin
      total++; bad++;
      $display("FAIL R12 actual=%0d pending expected=0", sbq.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule